// File: doc/BRIEF.md
# Interrupt Message Capture Queue

This block sits on the host side of a PCIe root and turns inbound message-signalled interrupts into queued records that software can read. Each inbound memory write reaches it as a one-cycle strobe carrying a 64-bit address and a 32-bit data word. When capture is on and the address falls inside a programmed window, the data and address are pushed into a 16-entry queue.

Software programs the window and drains the queue through an APB-style register port. It reads a pending flag, then the head entry's data word and its two address halves. The head entry leaves the queue only once all three words have been read. A single level interrupt output tells an upstream aggregator that records are waiting. The aggregator places it at bit 3 (mask 0x8) of its shared status word, beside the legacy interrupt bits at mask 0x1e0.

Software normally gives each vector v the message address window base + 4·v and the data value v, with a window of 4096 bytes. The block does not depend on this scheme: it stores whatever lands in the window.

Top module: `msi_capture`

## Requirements
- R1: After reset, every register reads zero, the pending flag is clear and `irq_o` is low.
- R2: The window base low word (offset 0x04), base high word (0x08), window size (0x0c) and enable bit 0 (0x14) are writable and read back. Read data appears on `prdata` in the cycle after the APB access phase (`psel` and `penable` both high).
- R3: An inbound write is stored only when enable is set and base ≤ address < base + size, with base = {high word, low word}. A write below the base, at base + size or above, or made while enable is clear, stores nothing.
- R4: Status (0x18) bit 0 reads 1 while at least one record is queued and 0 when the queue is empty.
- R5: Offset 0x20 returns the head record's data, 0x24 the low 32 bits of its address and 0x28 the high 32 bits.
- R6: The head record is removed only after each of 0x20, 0x24 and 0x28 has been read at least once, in any order. Reading the data word alone, or reading one word repeatedly, leaves the status unchanged.
- R7: Records leave in arrival order, and the queue holds up to 16 of them.
- R8: An inbound write that hits the window while 16 records are queued is dropped and sets status bit 1. Bit 1 stays set until software writes 1 to it.
- R9: Reads of 0x20, 0x24 or 0x28 while the queue is empty return zero and count toward no removal.
- R10: `irq_o` is high exactly when status bit 0 is 1 and enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound memory-write strobe |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered |
| irq_o | output | 1 | Level interrupt toward the aggregator |

## Verification
A queue pointer that is off by one shows up on the very next read of offset 0x20 as a vector number that is wrong or out of order, so every drained record is compared with its arithmetic expectation. A fault in the read-tracking state shows up as the status flag dropping one read too early or staying set one read too late, so the bench re-reads the status between the three word reads, using varied read orders. A fault in the window compare shows up only at the edges of the window, so the bench probes base − 4, base + size − 4 and base + size directly. A stuck overflow or interrupt term shows up within one APB read after the write-one-to-clear or after enable is toggled.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam logic [7:0] OFS_BASE_LO = 8'h04;
  localparam logic [7:0] OFS_BASE_HI = 8'h08;
  localparam logic [7:0] OFS_SIZE    = 8'h0c;
  localparam logic [7:0] OFS_ENABLE  = 8'h14;
  localparam logic [7:0] OFS_STATUS  = 8'h18;
  localparam logic [7:0] OFS_DATA    = 8'h20;
  localparam logic [7:0] OFS_ADDR_LO = 8'h24;
  localparam logic [7:0] OFS_ADDR_HI = 8'h28;

  localparam int MSG_ADDR_W = 64;
  localparam int MSG_DATA_W = 32;

  typedef struct packed {
    logic [MSG_ADDR_W-1:0] addr;
    logic [MSG_DATA_W-1:0] data;
  } msg_rec_t;

endpackage

// File: rtl/msi_win_match.sv
module msi_win_match #(
  parameter int AW = 64,
  parameter int SW = 32
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] size,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int LW = AW + 1;

  logic [LW-1:0] limit;
  logic          above_lo;
  logic          below_hi;

  always_comb begin
    limit    = {1'b0, base} + LW'(size);
    above_lo = (addr >= base);
    below_hi = ({1'b0, addr} < limit);
    hit      = en & above_lo & below_hi;
  end
endmodule

// File: rtl/msi_fifo.sv
module msi_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    full |-> !push) else $error("push into full queue"); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty) else $error("pop from empty queue"); // R9
  AST_PEND_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
    push |=> !empty) else $error("queue empty after push"); // R4
endmodule

// File: rtl/msi_pop_tracker.sv
module msi_pop_tracker (
  input  logic clk,
  input  logic rst,
  input  logic avail,
  input  logic rd_data,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic pop
);
  logic [2:0] seen;
  logic [2:0] seen_nxt;

  always_comb begin
    seen_nxt = seen;
    if (avail) seen_nxt = seen | {rd_hi, rd_lo, rd_data};
    pop = avail & (seen_nxt == 3'b111);
  end

  always_ff @(posedge clk) begin
    if (rst)      seen <= '0;
    else if (pop) seen <= '0;
    else          seen <= seen_nxt;
  end

  AST_TRACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    pop |=> (seen == 3'b000)) else $error("tracker not cleared"); // R6
  AST_SINGLE_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (seen == 3'b000) |-> !pop) else $error("pop before three reads"); // R6
endmodule

// File: rtl/msi_capture.sv
module msi_capture
  import msi_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PAW   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] in_addr,
  input  logic [31:0] in_data,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [PAW-1:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        irq_o
);
  localparam int REC_W = $bits(msg_rec_t);

  logic        acc, reg_wr, reg_rd;
  logic [31:0] base_lo, base_hi, win_size;
  logic        cap_en, ovf;
  logic        hit, push, pop, empty, full;
  logic        rd_data, rd_lo, rd_hi;
  msg_rec_t    rec_in, rec_head;
  logic [REC_W-1:0] head_bits;
  logic [31:0] rd_mux;

  assign acc    = psel & penable;
  assign reg_wr = acc & pwrite;
  assign reg_rd = acc & ~pwrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo  <= '0;
      base_hi  <= '0;
      win_size <= '0;
      cap_en   <= 1'b0;
    end else if (reg_wr) begin
      case (paddr)
        OFS_BASE_LO: base_lo  <= pwdata;
        OFS_BASE_HI: base_hi  <= pwdata;
        OFS_SIZE:    win_size <= pwdata;
        OFS_ENABLE:  cap_en   <= pwdata[0];
        default: ;
      endcase
    end
  end

  msi_win_match #(.AW(64), .SW(32)) u_match (
    .en   (cap_en),
    .base ({base_hi, base_lo}),
    .size (win_size),
    .addr (in_addr),
    .hit  (hit)
  );

  assign push        = in_valid & hit & ~full;
  assign rec_in.addr = in_addr;
  assign rec_in.data = in_data;

  msi_fifo #(.DEPTH(DEPTH), .W(REC_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   (rec_in),
    .pop   (pop),
    .head  (head_bits),
    .empty (empty),
    .full  (full)
  );
  assign rec_head = msg_rec_t'(head_bits);

  assign rd_data = reg_rd & (paddr == OFS_DATA);
  assign rd_lo   = reg_rd & (paddr == OFS_ADDR_LO);
  assign rd_hi   = reg_rd & (paddr == OFS_ADDR_HI);

  msi_pop_tracker u_track (
    .clk     (clk),
    .rst     (rst),
    .avail   (~empty),
    .rd_data (rd_data),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi),
    .pop     (pop)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ovf <= 1'b0;
    else if (in_valid & hit & full)
      ovf <= 1'b1;
    else if (reg_wr && paddr == OFS_STATUS && pwdata[1])
      ovf <= 1'b0;
  end

  always_comb begin
    case (paddr)
      OFS_BASE_LO: rd_mux = base_lo;
      OFS_BASE_HI: rd_mux = base_hi;
      OFS_SIZE:    rd_mux = win_size;
      OFS_ENABLE:  rd_mux = {31'b0, cap_en};
      OFS_STATUS:  rd_mux = {30'b0, ovf, ~empty};
      OFS_DATA:    rd_mux = empty ? 32'b0 : rec_head.data;
      OFS_ADDR_LO: rd_mux = empty ? 32'b0 : rec_head.addr[31:0];
      OFS_ADDR_HI: rd_mux = empty ? 32'b0 : rec_head.addr[63:32];
      default:     rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         prdata <= '0;
    else if (reg_rd) prdata <= rd_mux;
  end

  assign irq_o = cap_en & ~empty;

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && paddr == OFS_DATA && empty) |=> (prdata == 32'b0))
    else $error("nonzero data from empty queue"); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(reg_wr && paddr == OFS_STATUS && pwdata[1])) |=> ovf)
    else $error("overflow bit lost"); // R8
  AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && empty && !reg_wr) |=> empty)
    else $error("capture while disabled"); // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> cap_en) else $error("irq with capture off"); // R10
endmodule

// File: tb/msi_capture_test.sv
module msi_capture_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_addr;
  logic [31:0] in_data;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [31:0] BLO  = 32'h2000_0000;
  localparam logic [31:0] BHI  = 32'h0000_0001;
  localparam logic [63:0] BASE = {BHI, BLO};
  localparam logic [31:0] WSZ  = 32'd4096;

  always #2 clk = ~clk;

  msi_capture uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    d = prdata;
  endtask

  task automatic inbound(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_word(input int w, input int v, input logic [63:0] exp_addr);
    logic [31:0] r;
    case (w)
      0: begin apb_rd(8'h20, r); check("R5 data", r, v); end
      1: begin apb_rd(8'h24, r); check("R5 addr lo", r, exp_addr[31:0]); end
      default: begin apb_rd(8'h28, r); check("R5 addr hi", r, exp_addr[63:32]); end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; in_valid = 1'b0; in_addr = '0; in_data = '0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    apb_rd(8'h18, r); check("R1 status", r, 0);
    apb_rd(8'h04, r); check("R1 base lo", r, 0);
    apb_rd(8'h14, r); check("R1 enable", r, 0);
    check("R1 irq", irq_o, 0);

    // R2: register readback
    apb_wr(8'h04, BLO); apb_wr(8'h08, BHI); apb_wr(8'h0c, WSZ);
    apb_rd(8'h04, r); check("R2 base lo", r, BLO);
    apb_rd(8'h08, r); check("R2 base hi", r, BHI);
    apb_rd(8'h0c, r); check("R2 size", r, WSZ);

    // R3: disabled capture ignored
    inbound(BASE, 32'h5);
    apb_rd(8'h18, r); check("R3 disabled", r, 0);

    apb_wr(8'h14, 32'h1);
    apb_rd(8'h14, r); check("R2 enable", r, 1);

    // R3: window edges outside
    inbound(BASE - 64'd4, 32'h7);
    inbound(BASE + 64'(WSZ), 32'h8);
    apb_rd(8'h18, r); check("R3 outside window", r, 0);
    check("R10 irq idle", irq_o, 0);

    // R7: fill with 16 vectors
    for (int v = 0; v < 16; v++) inbound(BASE + 64'(4 * v), 32'(v));
    apb_rd(8'h18, r); check("R4 pending", r, 1);
    check("R10 irq high", irq_o, 1);

    // R8: overflow drop
    inbound(BASE + 64'd200, 32'hdead);
    apb_rd(8'h18, r); check("R8 overflow set", r, 3);

    // R6/R7: drain in varied orders
    for (int v = 0; v < 16; v++) begin
      logic [63:0] ea;
      ea = BASE + 64'(4 * v);
      case (v % 3)
        0: begin
          read_word(0, v, ea);
          apb_rd(8'h18, r); check("R6 data read alone keeps status", r[0], 1);
          read_word(0, v, ea);
          read_word(1, v, ea); read_word(2, v, ea);
        end
        1: begin read_word(2, v, ea); read_word(0, v, ea); read_word(1, v, ea); end
        default: begin
          read_word(1, v, ea); read_word(1, v, ea);
          read_word(2, v, ea);
          apb_rd(8'h18, r); check("R6 two of three keeps status", r[0], 1);
          read_word(0, v, ea);
        end
      endcase
    end
    apb_rd(8'h18, r); check("R4 empty after drain", r, 2);
    check("R10 irq low", irq_o, 0);

    // R8: write-one-to-clear
    apb_wr(8'h18, 32'h0);
    apb_rd(8'h18, r); check("R8 sticky", r, 2);
    apb_wr(8'h18, 32'h2);
    apb_rd(8'h18, r); check("R8 cleared", r, 0);

    // R9: empty reads return zero, no tracking
    apb_rd(8'h20, r); check("R9 empty data", r, 0);
    apb_rd(8'h24, r); check("R9 empty lo", r, 0);
    apb_rd(8'h28, r); check("R9 empty hi", r, 0);
    inbound(BASE + 64'(WSZ) - 64'd4, 32'habcd);
    apb_rd(8'h18, r); check("R3 last word in window", r, 1);
    apb_rd(8'h20, r); check("R5 data", r, 32'habcd);
    apb_rd(8'h24, r); check("R5 addr lo", r, BLO + WSZ - 4);
    apb_rd(8'h18, r); check("R9 no early pop", r, 1);
    apb_rd(8'h28, r); check("R5 addr hi", r, BHI);
    apb_rd(8'h18, r); check("R6 pop after third", r, 0);

    // R10: enable gates irq
    inbound(BASE + 64'd8, 32'h2);
    check("R10 irq on", irq_o, 1);
    apb_wr(8'h14, 32'h0);
    check("R10 irq gated", irq_o, 0);
    apb_rd(8'h18, r); check("R4 pending while disabled", r, 1);
    apb_wr(8'h14, 32'h1);
    check("R10 irq restored", irq_o, 1);
    read_word(0, 2, BASE + 64'd8); read_word(1, 2, BASE + 64'd8); read_word(2, 2, BASE + 64'd8);
    apb_rd(8'h18, r); check("R4 empty", r, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule